// File: doc/BRIEF.md
# Sigma-Delta Converter Calibration and Result Scaler

This block is the digital back end of a sigma-delta converter. Each time the front end signals that a conversion is done, the block takes the raw 16-bit sample. In continuous mode it removes the stored offset, applies the stored gain correction and writes the clamped result to the data register. It also flags the sample as invalid when the reference was missing.

Writing a calibration code to the 3-bit mode field starts a calibration. There are four kinds: zero-scale or full-scale, each with the input taken either internally or from the system pins. The calibration averages a number of conversion results. That number depends on the kind of calibration, the chop setting and the gain. From the average it derives a new coefficient, sets the ready flag and drops the block back to idle. If the reference disappears at any point during a calibration, the coefficients are left untouched and an error flag is raised.

The modulator, the filter and the serial register access are outside this block. Only the combined data-out/ready pin behaviour is modelled, as a level gated by chip select.

Top module: `adc_cal_scaler`

## Requirements
- R1: In continuous mode (mode 000), a conv_done strobe with ref_ok high loads data_out one clock later. The value is 0x8000 + floor((raw − offset) × fullscale / 2^15), where offset and fullscale are the coefficient outputs.
- R2: The scaled result is clamped to the range 0x0000..0xFFFF and never wraps.
- R3: Mode codes are 000 continuous and 001/010/011 idle. Codes 1xx are calibrations: bit 0 selects full-scale (1) or zero-scale (0), and bit 1 selects system (1) or internal (0). int_cal_sel is high exactly while an internal calibration (100 or 101) is running.
- R4: In the idle codes, conv_done strobes are ignored: data_out, rdy and the coefficients keep their values.
- R5: A zero-scale calibration takes 2 strobes with chop_en=1 and 1 strobe with chop_en=0. It loads the offset coefficient with the floor average of the raw samples.
- R6: A full-scale calibration with gain_code 0 (unity gain) takes 2 strobes with chop_en=1 and 1 with chop_en=0. With any other gain code it takes 4 strobes with chop and 2 without. Let d be the floor average minus the offset. The full-scale coefficient becomes min(floor(32767 × 32768 / d), 0xFFFF), or 0xFFFF when d ≤ 0.
- R7: When a calibration finishes, the matching coefficient is updated, rdy goes to 1 and mode_out returns to 001.
- R8: dout_rdy_n is 0 only while cs_n is 0 and rdy is 1; otherwise it is 1.
- R9: If ref_ok is low at any strobe of a calibration, that calibration updates neither coefficient. It still finishes after its full count with err=1, rdy=1 and mode 001.
- R10: A continuous-mode strobe with ref_ok low loads data_out with 0xFFFF and sets noref. On every accepted strobe, noref is set to the inverse of ref_ok.
- R11: A mode write clears rdy on the next clock. A mode write that starts a calibration also clears err. A conv_done in the same cycle as a mode write is ignored.
- R12: After reset: mode 000, offset 0x8000, full-scale 0x8000, data 0, rdy/err/noref 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Strobe that loads mode_in |
| mode_in | input | 3 | New mode code |
| conv_done | input | 1 | Conversion-done strobe |
| raw_data | input | 16 | Raw conversion result |
| ref_ok | input | 1 | Reference valid for this conversion |
| chop_en | input | 1 | Chopping enabled |
| gain_code | input | 3 | Gain setting, 0 means unity |
| cs_n | input | 1 | Chip select, active low |
| data_out | output | 16 | Data register |
| offset_coef | output | 16 | Offset coefficient |
| fscale_coef | output | 16 | Full-scale coefficient |
| mode_out | output | 3 | Current mode code |
| int_cal_sel | output | 1 | Internal calibration input selected |
| rdy | output | 1 | Ready status |
| err | output | 1 | Calibration error status |
| noref | output | 1 | No-reference status |
| dout_rdy_n | output | 1 | Combined data-out/ready level |

## Verification
The hardest case to reach is a reference drop on the final strobe of a multi-strobe full-scale calibration. The error path must win over the start of the divider, and both coefficients must hold even though the average is perfectly usable. The stimulus drives that case directly with a four-strobe calibration (chop on, non-unity gain) whose last sample carries ref_ok low. A later calibration then shows that err clears and the coefficients move again. Random rounds recalibrate from random samples, which include averages below the offset, before running bursts of conversions with occasional reference loss, so the clamp limits are hit from both sides.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   localparam logic [2:0] MD_CONT   = 3'b000;
   localparam logic [2:0] MD_IDLE   = 3'b001;
   localparam logic [2:0] MD_ZS_INT = 3'b100;
   localparam logic [2:0] MD_FS_INT = 3'b101;
   localparam logic [2:0] MD_ZS_SYS = 3'b110;
   localparam logic [2:0] MD_FS_SYS = 3'b111;

   // log2 of the number of conversion strobes a calibration averages
   function automatic logic [1:0] cal_shift(input logic full_scale,
                                            input logic chop,
                                            input logic unity_gain);
      if (!full_scale || unity_gain) return chop ? 2'd1 : 2'd0;
      return chop ? 2'd2 : 2'd1;
   endfunction
endpackage

// File: rtl/adc_cal_scale.sv
module adc_cal_scale #(
   parameter int DW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic [DW-1:0] raw,
   input  logic [DW-1:0] offset,
   input  logic [DW-1:0] gain,
   output logic [DW-1:0] result
);
   localparam int PW   = 2*DW + 2;
   localparam int FRAC = DW - 1;
   localparam logic signed [PW-1:0] MID  = PW'(1) << (DW-1);
   localparam logic signed [PW-1:0] MAXV = (PW'(1) << DW) - PW'(1);

   logic signed [DW:0]   diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;

   always_comb begin
      diff   = $signed({1'b0, raw}) - $signed({1'b0, offset});
      prod   = $signed({{(DW+1){diff[DW]}}, diff}) * $signed({{(DW+2){1'b0}}, gain});
      biased = (prod >>> FRAC) + MID;
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (biased < 0)         result = '0;
            else if (biased > MAXV) result = '1;
            else                    result = biased[DW-1:0];
         end
      end else begin : g_wrap
         always_comb result = biased[DW-1:0];
      end
   endgenerate
endmodule

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW:0]   den,
   output logic          done,
   output logic [DW-1:0] quo
);
   localparam int NW = 2*DW - 1;
   localparam int RW = DW + 2;
   localparam int CW = $clog2(NW + 1);
   localparam logic [NW-1:0] NUM = ((NW'(1) << (DW-1)) - NW'(1)) << (DW-1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [RW-1:0] rem_q;
   logic [NW-1:0] q_q;
   logic [DW:0]   den_q;
   logic [RW-1:0] trial;
   logic          fits;

   always_comb begin
      trial = {rem_q[RW-2:0], NUM[cnt_q - CW'(1)]};
      fits  = trial >= {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         q_q    <= '0;
         den_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(NW);
            rem_q  <= '0;
            q_q    <= '0;
            den_q  <= den;
         end else if (busy_q) begin
            rem_q <= fits ? trial - {1'b0, den_q} : trial;
            q_q   <= {q_q[NW-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign quo = (|q_q[NW-1:DW]) ? '1 : q_q[DW-1:0];
endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
   import adc_cal_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_wr,
   input  logic [2:0]    mode_in,
   input  logic          conv_done,
   input  logic [DW-1:0] raw,
   input  logic          ref_ok,
   input  logic          chop_en,
   input  logic [2:0]    gain_code,
   input  logic [DW-1:0] scaled,
   input  logic          div_done,
   input  logic [DW-1:0] div_quo,
   output logic          div_start,
   output logic [DW:0]   div_den,
   output logic [2:0]    mode_q,
   output logic [DW-1:0] off_q,
   output logic [DW-1:0] fs_q,
   output logic [DW-1:0] data_q,
   output logic          rdy_q,
   output logic          err_q,
   output logic          noref_q
);
   localparam int AW = DW + 2;
   localparam logic [DW-1:0] COEF_RST = DW'(1) << (DW-1);

   logic [1:0]           sh_q;
   logic [2:0]           cnt_q;
   logic [AW-1:0]        acc_q;
   logic                 bad_q;
   logic                 wait_q;
   logic [AW-1:0]        acc_nx;
   logic [DW-1:0]        avg;
   logic signed [DW+1:0] dfs;
   logic                 last;
   logic                 bad_now;
   logic                 cal_go;

   always_comb begin
      acc_nx    = acc_q + AW'(raw);
      avg       = DW'(acc_nx >> sh_q);
      dfs       = $signed({2'b00, avg}) - $signed({2'b00, off_q});
      last      = (cnt_q + 3'd1) == (3'd1 << sh_q);
      bad_now   = bad_q | ~ref_ok;
      cal_go    = mode_q[2] && conv_done && !mode_wr && !wait_q
                  && (cnt_q != (3'd1 << sh_q));
      div_start = cal_go && last && !bad_now && mode_q[0] && (dfs > 0);
      div_den   = dfs[DW:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MD_CONT;
         off_q   <= COEF_RST;
         fs_q    <= COEF_RST;
         data_q  <= '0;
         rdy_q   <= 1'b0;
         err_q   <= 1'b0;
         noref_q <= 1'b0;
         sh_q    <= '0;
         cnt_q   <= '0;
         acc_q   <= '0;
         bad_q   <= 1'b0;
         wait_q  <= 1'b0;
      end else if (mode_wr) begin
         mode_q <= mode_in;
         rdy_q  <= 1'b0;
         cnt_q  <= '0;
         acc_q  <= '0;
         bad_q  <= 1'b0;
         wait_q <= 1'b0;
         sh_q   <= cal_shift(mode_in[0], chop_en, gain_code == 3'd0);
         if (mode_in[2]) err_q <= 1'b0;
      end else begin
         if (mode_q == MD_CONT && conv_done) begin
            data_q  <= ref_ok ? scaled : '1;
            noref_q <= ~ref_ok;
            rdy_q   <= 1'b1;
         end
         if (cal_go) begin
            acc_q   <= acc_nx;
            cnt_q   <= cnt_q + 3'd1;
            noref_q <= ~ref_ok;
            if (!ref_ok) bad_q <= 1'b1;
            if (last) begin
               if (bad_now) begin
                  err_q  <= 1'b1;
                  rdy_q  <= 1'b1;
                  mode_q <= MD_IDLE;
               end else if (!mode_q[0]) begin
                  off_q  <= avg;
                  rdy_q  <= 1'b1;
                  mode_q <= MD_IDLE;
               end else if (dfs > 0) begin
                  wait_q <= 1'b1;
               end else begin
                  fs_q   <= '1;
                  rdy_q  <= 1'b1;
                  mode_q <= MD_IDLE;
               end
            end
         end
         if (div_done && wait_q) begin
            fs_q   <= div_quo;
            rdy_q  <= 1'b1;
            mode_q <= MD_IDLE;
            wait_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adc_cal_scaler.sv
module adc_cal_scaler #(
   parameter int DW       = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_wr,
   input  logic [2:0]    mode_in,
   input  logic          conv_done,
   input  logic [DW-1:0] raw_data,
   input  logic          ref_ok,
   input  logic          chop_en,
   input  logic [2:0]    gain_code,
   input  logic          cs_n,
   output logic [DW-1:0] data_out,
   output logic [DW-1:0] offset_coef,
   output logic [DW-1:0] fscale_coef,
   output logic [2:0]    mode_out,
   output logic          int_cal_sel,
   output logic          rdy,
   output logic          err,
   output logic          noref,
   output logic          dout_rdy_n
);
   generate
      if (DW < 8 || DW > 24) begin : g_dw_check
         $error("adc_cal_scaler: DW must lie in 8..24");
      end
   endgenerate

   logic [DW-1:0] scaled;
   logic          div_start;
   logic [DW:0]   div_den;
   logic          div_done;
   logic [DW-1:0] div_quo;

   adc_cal_scale #(.DW(DW), .SATURATE(SATURATE)) u_scale (
      .raw(raw_data), .offset(offset_coef), .gain(fscale_coef), .result(scaled)
   );

   adc_cal_div #(.DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .den(div_den),
      .done(div_done), .quo(div_quo)
   );

   adc_cal_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
      .conv_done(conv_done), .raw(raw_data), .ref_ok(ref_ok),
      .chop_en(chop_en), .gain_code(gain_code), .scaled(scaled),
      .div_done(div_done), .div_quo(div_quo), .div_start(div_start),
      .div_den(div_den), .mode_q(mode_out), .off_q(offset_coef),
      .fs_q(fscale_coef), .data_q(data_out), .rdy_q(rdy), .err_q(err),
      .noref_q(noref)
   );

   assign int_cal_sel = mode_out[2] & ~mode_out[1];
   assign dout_rdy_n  = cs_n | ~rdy;
endmodule

// File: rtl/adc_cal_scaler_chk.sv
module adc_cal_scaler_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_wr,
   input logic [2:0]    mode_in,
   input logic          conv_done,
   input logic [DW-1:0] raw_data,
   input logic          ref_ok,
   input logic          chop_en,
   input logic [2:0]    gain_code,
   input logic          cs_n,
   input logic [DW-1:0] data_out,
   input logic [DW-1:0] offset_coef,
   input logic [DW-1:0] fscale_coef,
   input logic [2:0]    mode_out,
   input logic          int_cal_sel,
   input logic          rdy,
   input logic          err,
   input logic          noref,
   input logic          dout_rdy_n
);
   p_pin_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> dout_rdy_n);

   p_noref_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !mode_wr && mode_out == 3'b000 && !ref_ok)
      |=> (data_out == '1 && noref));

   p_coef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($stable(offset_coef) && $stable(fscale_coef)));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_wr && mode_out[2] == 1'b0 && mode_out != 3'b000)
      |=> ($stable(data_out) && $stable(offset_coef) && $stable(fscale_coef)));

   p_rdy_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !rdy);

   p_cal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !$past(rdy) && $past(mode_out[2])) |-> (mode_out == 3'b001));
endmodule

bind adc_cal_scaler adc_cal_scaler_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_adc_cal_scaler.sv
module sim_adc_cal_scaler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_in = 3'b000;
   logic        conv_done = 1'b0;
   logic [15:0] raw_data = '0;
   logic        ref_ok = 1'b1;
   logic        chop_en = 1'b0;
   logic [2:0]  gain_code = 3'd0;
   logic        cs_n = 1'b1;
   logic [15:0] data_out, offset_coef, fscale_coef;
   logic [2:0]  mode_out;
   logic        int_cal_sel, rdy, err, noref, dout_rdy_n;

   int total = 0;
   int bad = 0;
   bit wd_hit = 1'b0;
   int unsigned off_m = 32'h8000;
   int unsigned fs_m  = 32'h8000;

   always #5 clk = ~clk;

   adc_cal_scaler u0 (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned exp_scale(int unsigned r, int unsigned o, int unsigned g);
      longint s;
      s = ((longint'(r) - longint'(o)) * longint'(g)) >>> 15;
      s = s + 32768;
      if (s < 0) return 0;
      if (s > 65535) return 65535;
      return int'(s);
   endfunction

   function automatic int unsigned exp_fs(int unsigned avg, int unsigned o);
      longint d, q;
      d = longint'(avg) - longint'(o);
      if (d <= 0) return 65535;
      q = (longint'(32767) * 32768) / d;
      return (q > 65535) ? 65535 : int'(q);
   endfunction

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_in = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic conv(input logic [15:0] r, input bit refv);
      @(negedge clk); conv_done = 1'b1; raw_data = r; ref_ok = refv;
      @(negedge clk); conv_done = 1'b0; ref_ok = 1'b1;
   endtask

   task automatic wait_rdy();
      for (int i = 0; i < 200 && !rdy; i++) @(negedge clk);
   endtask

   task automatic do_cal(input logic [2:0] m, input bit chop, input logic [2:0] gc,
                         input logic [15:0] s0, s1, s2, s3, input bit drop);
      int n;
      int unsigned sum;
      logic [15:0] smp [4];
      smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
      n = (!m[0] || gc == 3'd0) ? (chop ? 2 : 1) : (chop ? 4 : 2);
      sum = 0;
      chop_en = chop; gain_code = gc;
      set_mode(m);
      chk("R11 rdy cleared by mode write", rdy, 0);
      chk("R11 err cleared at calibration start", err, 0);
      chk("R3 internal input select", int_cal_sel, !m[1]);
      for (int i = 0; i < n; i++) begin
         conv(smp[i], !(drop && i == n-1));
         sum += smp[i];
         if (i < n-1) begin
            chk(m[0] ? "R6 full-scale strobe count" : "R5 zero-scale strobe count", rdy, 0);
            chk("R3 mode held during calibration", mode_out, m);
         end
      end
      wait_rdy();
      if (!drop) begin
         if (!m[0]) off_m = sum / n;
         else       fs_m  = exp_fs(sum / n, off_m);
      end
      chk("R7 ready after calibration", rdy, 1);
      chk("R7 back to idle", mode_out, 3'b001);
      chk("R9 error flag", err, drop);
      chk(drop ? "R9 offset held" : "R5 offset coefficient", offset_coef, off_m);
      chk(drop ? "R9 full-scale held" : "R6 full-scale coefficient", fscale_coef, fs_m);
   endtask

   task automatic conv_chk(input logic [15:0] r, input bit refv, input string req);
      conv(r, refv);
      chk(req, data_out, refv ? exp_scale(r, off_m, fs_m) : 65535);
      chk("R10 noref follows reference", noref, !refv);
      chk("R1 ready after conversion", rdy, 1);
   endtask

   task automatic run_all();
      logic [15:0] keep;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 mode", mode_out, 0);
      chk("R12 offset", offset_coef, 16'h8000);
      chk("R12 full-scale", fscale_coef, 16'h8000);
      chk("R12 data", data_out, 0);
      chk("R12 rdy", rdy, 0);
      chk("R12 err", err, 0);
      chk("R12 noref", noref, 0);
      chk("R8 pin while deselected", dout_rdy_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      conv_chk(16'h1234, 1'b1, "R1 default coefficients pass raw through");

      // R5 internal zero-scale with chop, then R8 pin gating
      do_cal(3'b100, 1'b1, 3'd0, 16'h8103, 16'h8110, 0, 0, 1'b0);
      cs_n = 1'b0; @(negedge clk);
      chk("R8 pin low when selected and ready", dout_rdy_n, 0);
      cs_n = 1'b1; @(negedge clk);
      chk("R8 pin high when deselected", dout_rdy_n, 1);

      // R4 idle codes ignore conversions
      keep = data_out;
      set_mode(3'b001);
      conv(16'h4444, 1'b1);
      chk("R4 idle data held", data_out, keep);
      chk("R4 idle rdy held", rdy, 0);
      set_mode(3'b011);
      conv(16'hFFF0, 1'b1);
      chk("R4 idle code 011 data held", data_out, keep);

      // R6 system full-scale, unity gain, no chop: one strobe
      do_cal(3'b111, 1'b0, 3'd0, 16'hC000, 0, 0, 0, 1'b0);
      // R6 internal full-scale, gain>1, chop: four strobes
      do_cal(3'b101, 1'b1, 3'd3, 16'hF000, 16'hF100, 16'hF200, 16'hF301, 1'b0);
      // R6 average below offset gives maximum coefficient
      do_cal(3'b111, 1'b0, 3'd2, 16'h0100, 16'h0200, 0, 0, 1'b0);
      chk("R6 non-positive span", fscale_coef, 16'hFFFF);

      // R2 clamping from both ends
      set_mode(3'b000);
      conv_chk(16'hFFFF, 1'b1, "R2 clamp high");
      conv_chk(16'h0000, 1'b1, "R2 clamp low");
      // R10 reference lost during conversion
      conv_chk(16'h2222, 1'b0, "R10 all ones on lost reference");

      // R9 reference lost on final strobe of a four-strobe calibration
      do_cal(3'b101, 1'b1, 3'd5, 16'hE000, 16'hE100, 16'hE200, 16'hE300, 1'b1);
      do_cal(3'b110, 1'b0, 3'd0, 16'h7F00, 0, 0, 0, 1'b1);
      // R11 error cleared and coefficients move again
      do_cal(3'b110, 1'b0, 3'd0, 16'h7F80, 0, 0, 0, 1'b0);

      // random rounds
      for (int rnd = 0; rnd < 4; rnd++) begin
         do_cal({2'b11, 1'b0} ^ {1'b0, rnd[0], 1'b0}, rnd[1], 3'd0,
                16'h7000 + 16'($urandom_range(0, 16'h2000)),
                16'h7000 + 16'($urandom_range(0, 16'h2000)), 0, 0, 1'b0);
         do_cal({2'b10, 1'b1} ^ {1'b0, rnd[1], 1'b0}, rnd[0], 3'($urandom_range(0, 7)),
                16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'b0);
         set_mode(3'b000);
         for (int k = 0; k < 40; k++)
            conv_chk(16'($urandom), ($urandom_range(0, 15) != 0), "R1 random conversion");
         conv_chk(16'hFFFF, 1'b1, "R2 random-round high end");
         conv_chk(16'h0000, 1'b1, "R2 random-round low end");
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule